// File: doc/BRIEF.md
# Streaming-Write Allocation Mode Detector

This block sits next to the bus interface of a write-back L1 data cache. It decides, for each store that misses, whether the miss handler should allocate a line (a linefill) or send the store straight to L2. Normally both read misses and write misses allocate. The block records which bytes the core stores into each line while that line's linefill is still outstanding. When a run of consecutive linefills is fully overwritten before the fill data arrives, the core is streaming writes, and fetching those lines is wasted work. The block then switches write allocation off.

The main state machine has two states. `RA_WALLOC` is the normal write-allocate state. `RA_RALLOC` is the read-allocate state, in which store misses go to L2 and loads still allocate normally. It has two transitions:
- Transition ENTER (`RA_WALLOC` to `RA_RALLOC`) fires on the completion of the `RA_THRESH`-th consecutive fully covered linefill.
- Transition LEAVE (`RA_RALLOC` to `RA_WALLOC`) fires on either of two events: a cacheable write burst to L2 that covers less than a line, or a load whose line address equals the line of the L2 write in flight.

A second state machine follows L2 writes. `L2_OFF` moves to `L2_ON` by transition L2_ENTER after `L2_THRESH` consecutive line-sized writes to L2. `L2_ON` moves back to `L2_OFF` by transition L2_LEAVE on any write to L2 that is smaller than a line. This second machine exists only when `L2_PRESENT` is set.

Each store miss is reported to the block through `st_miss`. One cycle later the block returns `miss_dec_valid` together with `miss_dec_to_l2`. The decision uses the mode held in the request cycle, so a mode change applies from the next miss onward.

Top module: `wstream_alloc_ctl`

## Requirements
- R1: After reset, `ra_mode`, `l2_ra_mode`, `miss_dec_valid` and `miss_dec_to_l2` are all 0. The block is in `RA_WALLOC` and `L2_OFF` with both run counters at zero.
- R2: Each linefill slot records which bytes are written. A `fill_start` on slot s clears that slot's byte mask and marks the slot busy with `fill_start_line`. A store (`st_valid`) sets, in every busy slot whose line equals `st_line`, the mask bits given by `st_be`. Bit i of `st_be` stands for byte i of the 64-byte line. A `fill_done` on a busy slot counts as fully covered only if all 64 bits were set in earlier cycles; a store in the same cycle as `fill_done` is not included. A `fill_done` on an idle slot is ignored.
- R3: In `RA_WALLOC`, the completion of the third consecutive fully covered linefill (`RA_THRESH`=3) sets `ra_mode` to 1 in the following cycle. After only two such completions, `ra_mode` stays 0.
- R4: In `RA_WALLOC`, the completion of a busy linefill that is not fully covered resets the consecutive count to zero.
- R5: When `st_miss` is 1 in cycle t, then in cycle t+1 `miss_dec_valid` is 1 and `miss_dec_to_l2` equals the value of `ra_mode` in cycle t. This holds even if the mode changes at the edge that ends cycle t. When `st_miss` is 0, both outputs are 0 in the next cycle.
- R6: In `RA_RALLOC`, an L2 write (`l2wr_valid`) with `l2wr_cacheable`=1 and `l2wr_full`=0 clears `ra_mode` in the next cycle. A non-cacheable partial write and a full-line write leave `ra_mode` at 1.
- R7: An L2 write makes its line in flight from the next cycle until the cycle after `l2wr_ack`. In `RA_RALLOC`, a load (`ld_valid`) whose `ld_line` equals the in-flight line clears `ra_mode` in the next cycle. A load to any other line, or a load after the ack, has no effect.
- R8: Leaving `RA_RALLOC` clears the consecutive count, so three new fully covered completions are needed before the block re-enters. Linefill completions while in `RA_RALLOC` do not change the mode.
- R9: With `L2_PRESENT`=1, the third consecutive L2 write with `l2wr_full`=1 (`L2_THRESH`=3) sets `l2_ra_mode` in the next cycle. Further full writes keep it set, because the counter saturates. Any L2 write with `l2wr_full`=0 clears both the counter and `l2_ra_mode` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_start | input | 1 | A linefill is allocated to a slot |
| fill_start_slot | input | SLOT_W (1) | Slot index of the new linefill |
| fill_start_line | input | LA_W (26) | Line address of the new linefill |
| st_valid | input | 1 | A store writes bytes of a line |
| st_line | input | LA_W (26) | Line address of the store |
| st_be | input | LINE_BYTES (64) | Byte enables of the store within the line |
| fill_done | input | 1 | A linefill completes |
| fill_done_slot | input | SLOT_W (1) | Slot index of the completing linefill |
| st_miss | input | 1 | A store lookup missed; an allocation decision is requested |
| l2wr_valid | input | 1 | A write burst to L2 is issued |
| l2wr_line | input | LA_W (26) | Line address of the L2 write |
| l2wr_cacheable | input | 1 | The L2 write is cacheable |
| l2wr_full | input | 1 | The L2 write covers a whole line |
| l2wr_ack | input | 1 | The in-flight L2 write has finished |
| ld_valid | input | 1 | A load is issued |
| ld_line | input | LA_W (26) | Line address of the load |
| ra_mode | output | 1 | 1 while in read-allocate mode (store misses do not allocate) |
| l2_ra_mode | output | 1 | 1 while the L2 read-allocate indication is active |
| miss_dec_valid | output | 1 | Allocation decision for the store miss of the previous cycle |
| miss_dec_to_l2 | output | 1 | 1: send that store to L2 without a linefill; 0: allocate |

## Verification
The bench builds the block with its defaults:
- two linefill slots,
- both thresholds at 3,
- `L2_PRESENT`=1.

These values let a few directed fills reach the ENTER and L2_ENTER transitions. They also let a small pool of four line addresses make store, fill and load collisions frequent under random stimulus. With two slots, the bench can exercise a store that matches an idle slot, a `fill_start` that reuses a slot, and completions on idle slots. A saturating 2-bit L2 counter is the smallest that still exposes the hold-at-threshold behaviour.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

    typedef enum logic {
        RA_WALLOC = 1'b0,
        RA_RALLOC = 1'b1
    } ra_state_t;

    typedef enum logic {
        L2_OFF = 1'b0,
        L2_ON  = 1'b1
    } l2_state_t;

endpackage

// File: rtl/wsa_fill_tracker.sv
module wsa_fill_tracker #(
    parameter int LINE_BYTES = 64,
    parameter int LA_W       = 26,
    parameter int SLOTS      = 2,
    parameter int SLOT_W     = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_start,
    input  logic [SLOT_W-1:0]     fill_start_slot,
    input  logic [LA_W-1:0]       fill_start_line,
    input  logic                  st_valid,
    input  logic [LA_W-1:0]       st_line,
    input  logic [LINE_BYTES-1:0] st_be,
    input  logic                  fill_done,
    input  logic [SLOT_W-1:0]     fill_done_slot,
    output logic                  done_full,
    output logic                  done_partial
);

    logic [SLOTS-1:0] slot_busy;
    logic [SLOTS-1:0] slot_cover;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic                  busy_q;
        logic [LA_W-1:0]       line_q;
        logic [LINE_BYTES-1:0] mask_q;
        logic                  hit_st;

        assign hit_st = st_valid && busy_q && (line_q == st_line);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q <= 1'b0;
                line_q <= '0;
                mask_q <= '0;
            end else begin
                if (fill_done && (fill_done_slot == SLOT_W'(g))) begin
                    busy_q <= 1'b0;
                end
                if (hit_st) begin
                    mask_q <= mask_q | st_be;
                end
                if (fill_start && (fill_start_slot == SLOT_W'(g))) begin
                    busy_q <= 1'b1;
                    line_q <= fill_start_line;
                    mask_q <= '0;
                end
            end
        end

        assign slot_busy[g]  = busy_q;
        assign slot_cover[g] = &mask_q;

        // R2: a slot that was just (re)allocated cannot report full coverage
        AST_FRESH_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_start && fill_start_slot == SLOT_W'(g)) |=> !slot_cover[g]); // R2
    end

    logic sel_busy;
    logic sel_cover;

    always_comb begin
        sel_busy  = 1'b0;
        sel_cover = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (fill_done_slot == SLOT_W'(i)) begin
                sel_busy  = slot_busy[i];
                sel_cover = slot_cover[i];
            end
        end
        done_full    = fill_done && sel_busy && sel_cover;
        done_partial = fill_done && sel_busy && !sel_cover;
    end

endmodule

// File: rtl/wsa_wb_tracker.sv
module wsa_wb_tracker #(
    parameter int LA_W = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            l2wr_valid,
    input  logic [LA_W-1:0] l2wr_line,
    input  logic            l2wr_cacheable,
    input  logic            l2wr_full,
    input  logic            l2wr_ack,
    input  logic            ld_valid,
    input  logic [LA_W-1:0] ld_line,
    output logic            exit_partial,
    output logic            load_hit
);

    logic            wb_busy_q;
    logic [LA_W-1:0] wb_line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_busy_q <= 1'b0;
            wb_line_q <= '0;
        end else begin
            if (l2wr_ack) begin
                wb_busy_q <= 1'b0;
            end
            if (l2wr_valid) begin
                wb_busy_q <= 1'b1;
                wb_line_q <= l2wr_line;
            end
        end
    end

    assign exit_partial = l2wr_valid && l2wr_cacheable && !l2wr_full;
    assign load_hit     = ld_valid && wb_busy_q && (ld_line == wb_line_q);

    // R7: a line match requires that an L2 write was issued before
    AST_HIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(l2wr_ack) && !$past(l2wr_valid)) |-> !load_hit); // R7

endmodule

// File: rtl/wsa_l2_mode.sv
module wsa_l2_mode
    import wsa_pkg::*;
#(
    parameter int L2_THRESH  = 3,
    parameter bit L2_PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic l2wr_valid,
    input  logic l2wr_full,
    output logic l2_on
);

    localparam int CNT_W = $clog2(L2_THRESH + 1);

    if (L2_PRESENT) begin : g_l2
        l2_state_t        st_q, st_n;
        logic [CNT_W-1:0] cnt_q, cnt_n;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= L2_OFF;
                cnt_q <= '0;
            end else begin
                st_q  <= st_n;
                cnt_q <= cnt_n;
            end
        end

        always_comb begin
            st_n  = st_q;
            cnt_n = cnt_q;
            if (l2wr_valid) begin
                if (l2wr_full) begin
                    if (cnt_q != CNT_W'(L2_THRESH)) begin
                        cnt_n = cnt_q + 1'b1;
                    end
                    unique case (st_q)
                        L2_OFF: if (cnt_n == CNT_W'(L2_THRESH)) st_n = L2_ON;
                        L2_ON:  st_n = L2_ON;
                        default: st_n = L2_OFF;
                    endcase
                end else begin
                    cnt_n = '0;
                    st_n  = L2_OFF;
                end
            end
        end

        assign l2_on = (st_q == L2_ON);

        AST_L2_PARTIAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (l2wr_valid && !l2wr_full) |=> !l2_on); // R9
        AST_L2_RISE_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(l2_on) |-> $past(l2wr_valid && l2wr_full)); // R9
        AST_L2_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(L2_THRESH)); // R9
    end else begin : g_no_l2
        assign l2_on = 1'b0;
    end

endmodule

// File: rtl/wstream_alloc_ctl.sv
module wstream_alloc_ctl
    import wsa_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int LA_W       = 26,
    parameter int SLOTS      = 2,
    parameter int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int RA_THRESH  = 3,
    parameter int L2_THRESH  = 3,
    parameter bit L2_PRESENT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_start,
    input  logic [SLOT_W-1:0]     fill_start_slot,
    input  logic [LA_W-1:0]       fill_start_line,
    input  logic                  st_valid,
    input  logic [LA_W-1:0]       st_line,
    input  logic [LINE_BYTES-1:0] st_be,
    input  logic                  fill_done,
    input  logic [SLOT_W-1:0]     fill_done_slot,
    input  logic                  st_miss,
    input  logic                  l2wr_valid,
    input  logic [LA_W-1:0]       l2wr_line,
    input  logic                  l2wr_cacheable,
    input  logic                  l2wr_full,
    input  logic                  l2wr_ack,
    input  logic                  ld_valid,
    input  logic [LA_W-1:0]       ld_line,
    output logic                  ra_mode,
    output logic                  l2_ra_mode,
    output logic                  miss_dec_valid,
    output logic                  miss_dec_to_l2
);

    localparam int RUN_W = $clog2(RA_THRESH + 1);

    logic done_full, done_partial;
    logic exit_partial, load_hit;

    wsa_fill_tracker #(
        .LINE_BYTES (LINE_BYTES),
        .LA_W       (LA_W),
        .SLOTS      (SLOTS),
        .SLOT_W     (SLOT_W)
    ) u_fill (
        .clk             (clk),
        .rst_n           (rst_n),
        .fill_start      (fill_start),
        .fill_start_slot (fill_start_slot),
        .fill_start_line (fill_start_line),
        .st_valid        (st_valid),
        .st_line         (st_line),
        .st_be           (st_be),
        .fill_done       (fill_done),
        .fill_done_slot  (fill_done_slot),
        .done_full       (done_full),
        .done_partial    (done_partial)
    );

    wsa_wb_tracker #(
        .LA_W (LA_W)
    ) u_wb (
        .clk            (clk),
        .rst_n          (rst_n),
        .l2wr_valid     (l2wr_valid),
        .l2wr_line      (l2wr_line),
        .l2wr_cacheable (l2wr_cacheable),
        .l2wr_full      (l2wr_full),
        .l2wr_ack       (l2wr_ack),
        .ld_valid       (ld_valid),
        .ld_line        (ld_line),
        .exit_partial   (exit_partial),
        .load_hit       (load_hit)
    );

    wsa_l2_mode #(
        .L2_THRESH  (L2_THRESH),
        .L2_PRESENT (L2_PRESENT)
    ) u_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .l2wr_valid (l2wr_valid),
        .l2wr_full  (l2wr_full),
        .l2_on      (l2_ra_mode)
    );

    // Main read-allocate state machine
    ra_state_t        st_q, st_n;
    logic [RUN_W-1:0] run_q, run_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RA_WALLOC;
            run_q <= '0;
        end else begin
            st_q  <= st_n;
            run_q <= run_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        run_n = run_q;
        unique case (st_q)
            RA_WALLOC: begin
                if (done_full) begin
                    if (run_q == RUN_W'(RA_THRESH - 1)) begin
                        st_n  = RA_RALLOC;   // ENTER
                        run_n = '0;
                    end else begin
                        run_n = run_q + 1'b1;
                    end
                end else if (done_partial) begin
                    run_n = '0;
                end
            end
            RA_RALLOC: begin
                run_n = '0;
                if (exit_partial || load_hit) begin
                    st_n = RA_WALLOC;        // LEAVE
                end
            end
            default: begin
                st_n  = RA_WALLOC;
                run_n = '0;
            end
        endcase
    end

    // Outputs and miss decision register
    logic dec_v_q, dec_l2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_v_q  <= 1'b0;
            dec_l2_q <= 1'b0;
        end else begin
            dec_v_q  <= st_miss;
            dec_l2_q <= st_miss && (st_q == RA_RALLOC);
        end
    end

    always_comb begin
        ra_mode        = (st_q == RA_RALLOC);
        miss_dec_valid = dec_v_q;
        miss_dec_to_l2 = dec_l2_q;
    end

    AST_ENTER_ON_FULL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ra_mode) |-> $past(done_full)); // R3
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RUN_W'(RA_THRESH)); // R4
    AST_DEC_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_dec_to_l2 |-> miss_dec_valid); // R5
    AST_LEAVE_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_mode && exit_partial) |=> !ra_mode); // R6
    AST_LEAVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_mode && load_hit) |=> !ra_mode); // R7
    AST_RA_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ra_mode |-> (run_q == '0)); // R8

endmodule

// File: tb/wstream_alloc_ctl_tb.sv
module wstream_alloc_ctl_tb_top;

    localparam int LB = 64;
    localparam int LA = 26;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fill_start;
    logic [0:0]    fill_start_slot;
    logic [LA-1:0] fill_start_line;
    logic          st_valid;
    logic [LA-1:0] st_line;
    logic [LB-1:0] st_be;
    logic          fill_done;
    logic [0:0]    fill_done_slot;
    logic          st_miss;
    logic          l2wr_valid;
    logic [LA-1:0] l2wr_line;
    logic          l2wr_cacheable;
    logic          l2wr_full;
    logic          l2wr_ack;
    logic          ld_valid;
    logic [LA-1:0] ld_line;
    logic          ra_mode, l2_ra_mode, miss_dec_valid, miss_dec_to_l2;

    always #10 clk = ~clk;

    wstream_alloc_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .fill_start(fill_start), .fill_start_slot(fill_start_slot), .fill_start_line(fill_start_line),
        .st_valid(st_valid), .st_line(st_line), .st_be(st_be),
        .fill_done(fill_done), .fill_done_slot(fill_done_slot),
        .st_miss(st_miss),
        .l2wr_valid(l2wr_valid), .l2wr_line(l2wr_line), .l2wr_cacheable(l2wr_cacheable),
        .l2wr_full(l2wr_full), .l2wr_ack(l2wr_ack),
        .ld_valid(ld_valid), .ld_line(ld_line),
        .ra_mode(ra_mode), .l2_ra_mode(l2_ra_mode),
        .miss_dec_valid(miss_dec_valid), .miss_dec_to_l2(miss_dec_to_l2)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    bit          m_busy [2];
    bit [LA-1:0] m_line [2];
    bit [LB-1:0] m_mask [2];
    int          m_run, m_l2cnt;
    bit          m_ra, m_l2, m_wbb, m_dv, m_dl2;
    bit [LA-1:0] m_wbl;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit next_ra(bit ra, bit full, bit part, bit leave, inout int run);
        if (ra) begin
            run = 0;
            return leave ? 1'b0 : 1'b1;
        end
        if (full) begin
            if (run == 2) begin run = 0; return 1'b1; end
            run++;
        end else if (part) begin
            run = 0;
        end
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_busy[i] = 0; m_line[i] = '0; m_mask[i] = '0;
        end
        m_run = 0; m_l2cnt = 0; m_ra = 0; m_l2 = 0; m_wbb = 0; m_wbl = '0; m_dv = 0; m_dl2 = 0;
    endtask

    task automatic model_step();
        bit          o_busy [2];
        bit [LA-1:0] o_line [2];
        bit full, part, leave;
        for (int i = 0; i < 2; i++) begin o_busy[i] = m_busy[i]; o_line[i] = m_line[i]; end
        full  = fill_done && o_busy[fill_done_slot] && (&m_mask[fill_done_slot]);
        part  = fill_done && o_busy[fill_done_slot] && !(&m_mask[fill_done_slot]);
        leave = (l2wr_valid && l2wr_cacheable && !l2wr_full) ||
                (ld_valid && m_wbb && ld_line == m_wbl);
        m_dv  = st_miss;
        m_dl2 = st_miss && m_ra;
        m_ra  = next_ra(m_ra, full, part, leave, m_run);
        for (int i = 0; i < 2; i++) begin
            if (fill_done && fill_done_slot == i[0]) m_busy[i] = 0;
            if (st_valid && o_busy[i] && o_line[i] == st_line) m_mask[i] |= st_be;
            if (fill_start && fill_start_slot == i[0]) begin
                m_busy[i] = 1; m_line[i] = fill_start_line; m_mask[i] = '0;
            end
        end
        if (l2wr_ack) m_wbb = 0;
        if (l2wr_valid) begin m_wbb = 1; m_wbl = l2wr_line; end
        if (l2wr_valid) begin
            if (l2wr_full) begin
                if (m_l2cnt < 3) m_l2cnt++;
                if (m_l2cnt == 3) m_l2 = 1;
            end else begin
                m_l2cnt = 0; m_l2 = 0;
            end
        end
    endtask

    task automatic clr_in();
        fill_start = 0; fill_start_slot = 0; fill_start_line = '0;
        st_valid = 0; st_line = '0; st_be = '0;
        fill_done = 0; fill_done_slot = 0; st_miss = 0;
        l2wr_valid = 0; l2wr_line = '0; l2wr_cacheable = 0; l2wr_full = 0; l2wr_ack = 0;
        ld_valid = 0; ld_line = '0;
    endtask

    // one clock: model update, edge, compare at falling edge, clear inputs
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R3 ra_mode model", ra_mode, m_ra);
        check("R9 l2_ra_mode model", l2_ra_mode, m_l2);
        check("R5 miss_dec_valid model", miss_dec_valid, m_dv);
        check("R5 miss_dec_to_l2 model", miss_dec_to_l2, m_dl2);
        clr_in();
    endtask

    task automatic do_fill(bit [LA-1:0] line, bit [LB-1:0] be);
        fill_start = 1; fill_start_slot = 0; fill_start_line = line; cyc();
        st_valid = 1; st_line = line; st_be = be; cyc();
        fill_done = 1; fill_done_slot = 0; cyc();
    endtask

    task automatic l2w(bit [LA-1:0] line, bit cach, bit full);
        l2wr_valid = 1; l2wr_line = line; l2wr_cacheable = cach; l2wr_full = full; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clr_in();
        model_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 ra_mode reset", ra_mode, 0);
        check("R1 l2_ra_mode reset", l2_ra_mode, 0);
        check("R1 miss_dec_valid reset", miss_dec_valid, 0);
        check("R1 miss_dec_to_l2 reset", miss_dec_to_l2, 0);

        // R3: two full fills are not enough, the third enters
        do_fill(26'h10, '1);
        do_fill(26'h11, '1);
        check("R3 two fills stay", ra_mode, 0);
        st_miss = 1; cyc();
        check("R5 alloc decision", miss_dec_to_l2, 0);
        check("R5 decision valid", miss_dec_valid, 1);
        do_fill(26'h12, '1);
        check("R3 third fill enters", ra_mode, 1);

        // R5 store miss in read-allocate
        st_miss = 1; cyc();
        check("R5 to_l2 decision", miss_dec_to_l2, 1);

        // R8 completions in read-allocate keep mode
        do_fill(26'h13, 64'h1);
        check("R8 partial fill ignored in RA", ra_mode, 1);

        // R6 non-cacheable partial and full writes do not exit
        l2w(26'h20, 0, 0);
        check("R6 noncacheable partial ignored", ra_mode, 1);
        l2w(26'h20, 1, 1);
        check("R6 full write ignored", ra_mode, 1);
        // exit with a store miss in the same cycle: old decision kept
        l2wr_valid = 1; l2wr_line = 26'h21; l2wr_cacheable = 1; l2wr_full = 0; st_miss = 1; cyc();
        check("R6 partial cacheable exits", ra_mode, 0);
        check("R5 pending miss keeps old decision", miss_dec_to_l2, 1);
        st_miss = 1; cyc();
        check("R5 next miss allocates", miss_dec_to_l2, 0);

        // R8 count cleared on exit
        do_fill(26'h30, '1);
        do_fill(26'h31, '1);
        check("R8 restart count", ra_mode, 0);
        // R4 partial fill resets run
        do_fill(26'h32, {32'h0, 32'hffffffff});
        do_fill(26'h33, '1);
        do_fill(26'h34, '1);
        check("R4 partial reset run", ra_mode, 0);
        do_fill(26'h35, '1);
        check("R4 fresh run enters", ra_mode, 1);

        // R7 load hit on in-flight line
        l2w(26'h40, 1, 1);
        ld_valid = 1; ld_line = 26'h41; cyc();
        check("R7 other-line load ignored", ra_mode, 1);
        ld_valid = 1; ld_line = 26'h40; cyc();
        check("R7 load to in-flight line exits", ra_mode, 0);

        // R7 load after ack has no effect
        do_fill(26'h50, '1); do_fill(26'h51, '1); do_fill(26'h52, '1);
        check("R3 re-enter", ra_mode, 1);
        l2wr_ack = 1; cyc();
        ld_valid = 1; ld_line = 26'h40; cyc();
        check("R7 load after ack ignored", ra_mode, 1);

        // R2 store in done cycle not counted; other line not counted
        l2w(26'h60, 1, 0);
        check("R6 leave before R2 test", ra_mode, 0);
        fill_start = 1; fill_start_slot = 1; fill_start_line = 26'h70; cyc();
        st_valid = 1; st_line = 26'h70; st_be = {1'b0, {63{1'b1}}}; cyc();
        st_valid = 1; st_line = 26'h71; st_be = '1; cyc();
        fill_done = 1; fill_done_slot = 1; st_valid = 1; st_line = 26'h70; st_be = '1; cyc();
        do_fill(26'h72, '1); do_fill(26'h73, '1);
        check("R2 partial coverage broke run", ra_mode, 0);
        // R2 idle-slot completion ignored, restart clears mask
        fill_done = 1; fill_done_slot = 1; cyc();
        do_fill(26'h74, '1);
        check("R2 idle done ignored", ra_mode, 1);
        l2w(26'h60, 1, 0);

        // R9 L2 mode
        l2w(26'h80, 1, 1); l2w(26'h81, 1, 1);
        check("R9 two writes not enough", l2_ra_mode, 0);
        l2w(26'h82, 0, 1);
        check("R9 third write enters", l2_ra_mode, 1);
        l2w(26'h83, 1, 1);
        check("R9 saturate holds", l2_ra_mode, 1);
        l2w(26'h84, 0, 0);
        check("R9 partial clears", l2_ra_mode, 0);
        l2w(26'h85, 1, 1); l2w(26'h86, 1, 1);
        check("R9 counter was cleared", l2_ra_mode, 0);

        // random phase against the model
        void'($urandom(32'h5a17));
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom % 100;
            fill_start = (r < 30); fill_start_slot = 1'($urandom); fill_start_line = LA'($urandom % 4);
            st_valid = ($urandom % 2 == 1); st_line = LA'($urandom % 4);
            st_be = ($urandom % 3 != 0) ? '1 : {$urandom, $urandom};
            fill_done = ($urandom % 4 == 0); fill_done_slot = 1'($urandom);
            st_miss = ($urandom % 3 == 0);
            l2wr_valid = ($urandom % 6 == 0); l2wr_line = LA'($urandom % 4);
            l2wr_cacheable = ($urandom % 4 != 0); l2wr_full = ($urandom % 4 != 0);
            l2wr_ack = ($urandom % 5 == 0);
            ld_valid = ($urandom % 8 == 0); ld_line = LA'($urandom % 4);
            cyc();
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule